// File: doc/BRIEF.md
# Command Phase Host Handshake

This block sits between a host and the engine that carries out commands. Each command goes through three phases in order: command, execution and result. In the command phase the host writes an opcode byte and then its parameter bytes. The block passes each byte to the back end one at a time. Once the last parameter byte has been consumed, the block waits for the back end to report that execution is finished. In the result phase the block fetches result bytes from the back end one at a time, and the host reads each one. After that the block returns to the command phase.

The host follows a status byte to pace its accesses. The request bit says that the data port is ready for a transfer. The direction bit says which way that transfer goes. A busy bit covers a whole command. A sticky error bit records any write the protocol did not allow. The low bits of the opcode give the number of parameter bytes and the number of result bytes, so no separate decode table is stored.

Top module: `cmd_handshake_ctrl`

## Requirements
- R1: After reset the status byte is 8'h80: request bit (bit 7) is 1, and the direction (bit 6), busy (bit 4) and error (bit 3) bits are 0. The other status bits always read 0.
- R2: The opcode's bits [2:0] give the parameter byte count (0 to 7). Its bits [4:3] give the result byte count (0 to 3). Bits [7:5] do not affect either count.
- R3: A host write is taken only while the request bit is 1 and the direction bit is 0. A byte that is taken is shown on `be_byte` with `be_valid` high, and stays unchanged until `be_ready` is sampled high. `be_first` is 1 for the opcode byte and 0 for parameter bytes.
- R4: The request bit goes to 0 in the cycle after a write is taken. It stays 0 until the back end consumes the byte. In the command phase it comes back to 1 in the cycle after `be_ready`, as long as parameter bytes are still owed.
- R5: When the last byte of a command has been consumed, the block enters execution. There the status byte is 8'h10, and it stays so until `be_done`.
- R6: In the result phase, `res_req` is high while no result byte is held. A byte offered with `res_valid` is latched onto `host_dout`, and the status byte becomes 8'hD0. A host read takes the byte, and the status byte becomes 8'h50 until the next byte arrives.
- R7: The block returns to the command phase (status 8'h80) in two cases: after the last result byte is read, or at `be_done` when the command has no result bytes.
- R8: The busy bit is set from the cycle after the opcode write is taken until the command ends.
- R9: A write made while the request bit is 0 or the direction bit is 1 is ignored: `be_byte`, `be_valid` and the phase do not change. It sets the error bit, which only reset clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe for a result byte |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Result byte for the host |
| status | output | 8 | Status byte: bit 7 request, bit 6 direction, bit 4 busy, bit 3 error |
| be_valid | output | 1 | A command byte is waiting for the back end |
| be_byte | output | 8 | Command byte for the back end |
| be_first | output | 1 | The waiting byte is the opcode |
| be_ready | input | 1 | Back end consumes the waiting byte |
| be_done | input | 1 | Back end has finished execution |
| res_req | output | 1 | Block asks the back end for a result byte |
| res_valid | input | 1 | Back end offers a result byte |
| res_data | input | 8 | Result byte from the back end |

## Verification
The bench runs every value of the five count bits, and some opcodes with the upper bits set. For each one it checks the status byte after every write, every consume, execution done and every read.

A design that decoded the counts wrongly would enter execution too early or too late, or return with a wrong number of result bytes. A design that raised the request bit before the back end consumed the byte would show 8'h90 where 8'h10 is expected. The zero-parameter and zero-result commands are aimed at off-by-one errors in the counters, which would hang the command or skip a phase.

Writes are also made while a byte is pending, during execution and during the result phase. A design that let any of them through would change `be_byte`, restart `be_valid` or leave the error bit clear.

// File: rtl/cmd_handshake_ctrl.sv
module cmd_handshake_ctrl #(
  parameter int DW    = 8,
  parameter int PBITS = 3,
  parameter int RBITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic [7:0]    status,
  output logic          be_valid,
  output logic [DW-1:0] be_byte,
  output logic          be_first,
  input  logic          be_ready,
  input  logic          be_done,
  output logic          res_req,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data
);

  localparam int CBITS = PBITS + RBITS;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} ph_t;

  ph_t              ph;
  logic             pend, busy, perr, res_have;
  logic [PBITS-1:0] prem;
  logic [RBITS-1:0] rleft;
  logic             rqm, dio, wr_ok;

  assign dio      = (ph == PH_RES);
  assign rqm      = (ph == PH_CMD) ? !pend : (ph == PH_RES) ? res_have : 1'b0;
  assign wr_ok    = host_wr && rqm && !dio;
  assign be_valid = pend;
  assign res_req  = (ph == PH_RES) && !res_have;
  assign status   = {rqm, dio, 1'b0, busy, perr, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_CMD;
      pend      <= 1'b0;
      busy      <= 1'b0;
      perr      <= 1'b0;
      res_have  <= 1'b0;
      prem      <= '0;
      rleft     <= '0;
      be_byte   <= '0;
      be_first  <= 1'b0;
      host_dout <= '0;
    end else begin
      if (host_wr && !wr_ok) perr <= 1'b1;
      case (ph)
        PH_CMD: begin
          if (wr_ok) begin
            pend     <= 1'b1;
            be_byte  <= host_din;
            be_first <= !busy;
            if (!busy) begin
              busy  <= 1'b1;
              prem  <= host_din[PBITS-1:0];
              rleft <= host_din[CBITS-1:PBITS];
            end else begin
              prem <= prem - 1'b1;
            end
          end
          if (pend && be_ready) begin
            pend <= 1'b0;
            if (prem == '0) ph <= PH_EXEC;
          end
        end
        PH_EXEC: begin
          if (be_done) begin
            if (rleft == '0) begin
              ph   <= PH_CMD;
              busy <= 1'b0;
            end else begin
              ph <= PH_RES;
            end
          end
        end
        PH_RES: begin
          if (!res_have && res_valid) begin
            res_have  <= 1'b1;
            host_dout <= res_data;
          end
          if (res_have && host_rd) begin
            res_have <= 1'b0;
            rleft    <= rleft - 1'b1;
            if (rleft == RBITS'(1)) begin
              ph   <= PH_CMD;
              busy <= 1'b0;
            end
          end
        end
        default: ph <= PH_CMD;
      endcase
    end
  end

  assert_rqm_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && status[7] && !status[6] |=> !status[7]);

  assert_byte_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid && !be_ready |=> be_valid && $stable(be_byte) && $stable(be_first));

  assert_bad_write_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !(status[7] && !status[6]) |=> status[3]);

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |=> status[3]);

  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] && status[6] && !host_rd |=> status[7] && $stable(host_dout));

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> status[7] && !status[6] && !be_valid);

  assert_no_req_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] && !status[6] && !be_valid |-> !res_req);

endmodule

// File: tb/cmd_handshake_ctrl_tb.sv
module cmd_handshake_ctrl_tb;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_din = '0;
  logic [7:0] host_dout, status, be_byte, res_data = '0;
  logic       be_valid, be_first, res_req;
  logic       be_ready = 1'b0, be_done = 1'b0, res_valid = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cmd_handshake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_din(host_din), .host_dout(host_dout), .status(status),
    .be_valid(be_valid), .be_byte(be_byte), .be_first(be_first),
    .be_ready(be_ready), .be_done(be_done), .res_req(res_req),
    .res_valid(res_valid), .res_data(res_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
    chk("R1 status", status, 8'h80);
    chk("R1 be_valid", {7'd0, be_valid}, 8'h00);
  endtask

  task automatic wr(input logic [7:0] d);
    host_din = d;
    host_wr = 1'b1;
    step();
    host_wr = 1'b0;
  endtask

  task automatic consume;
    be_ready = 1'b1;
    step();
    be_ready = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op);
    int np, nr;
    np = op % 8;
    nr = (op / 8) % 4;
    for (int k = 0; k <= np; k++) begin
      logic [7:0] d;
      d = (k == 0) ? op : 8'(op * 3 + k * 17);
      chk("R3 ready to write", status, (k == 0) ? 8'h80 : 8'h90);
      wr(d);
      chk("R4 rqm low after write", status, 8'h10);
      chk("R3 byte shown", be_byte, d);
      chk("R3 first flag", {7'd0, be_first}, (k == 0) ? 8'h01 : 8'h00);
      chk("R8 busy/valid", {7'd0, be_valid}, 8'h01);
      consume();
      chk("R4 R5 after consume", status, (k == np) ? 8'h10 : 8'h90);
    end
    step();
    chk("R5 exec waits", status, 8'h10);
    be_done = 1'b1;
    step();
    be_done = 1'b0;
    if (nr == 0) begin
      chk("R7 R2 no results", status, 8'h80);
    end else begin
      for (int j = 0; j < nr; j++) begin
        chk("R6 res_req", {7'd0, res_req}, 8'h01);
        chk("R6 waiting", status, 8'h50);
        res_data = 8'(8'hA0 + j + op);
        res_valid = 1'b1;
        step();
        res_valid = 1'b0;
        chk("R6 ready", status, 8'hD0);
        chk("R6 data", host_dout, 8'(8'hA0 + j + op));
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        chk("R7 R2 after read", status, (j == nr - 1) ? 8'h80 : 8'h50);
      end
    end
  endtask

  initial begin
    do_reset();
    for (int o = 0; o < 32; o++) run_cmd(8'(o));
    run_cmd(8'hE5);
    run_cmd(8'hA8);

    // R9: write while byte pending
    wr(8'h02);
    wr(8'h55);
    chk("R9 pending write ignored", be_byte, 8'h02);
    chk("R9 flag set", status, 8'h18);
    consume();
    chk("R9 flow continues", status, 8'h98);
    wr(8'h11); consume();
    wr(8'h22); consume();
    wr(8'h77);
    chk("R9 exec write ignored", {7'd0, be_valid}, 8'h00);
    chk("R9 exec state kept", status, 8'h18);
    do_reset();

    // R9: write during result phase
    wr(8'h08); consume();
    be_done = 1'b1; step(); be_done = 1'b0;
    res_data = 8'h3C; res_valid = 1'b1; step(); res_valid = 1'b0;
    wr(8'h99);
    chk("R9 result write ignored", status, 8'hD8);
    chk("R9 no byte offered", {7'd0, be_valid}, 8'h00);
    chk("R9 data kept", host_dout, 8'h3C);
    host_rd = 1'b1; step(); host_rd = 1'b0;
    chk("R9 sticky after command", status, 8'h88);
    do_reset();
    chk("R9 cleared by reset", status, 8'h80);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule